// File: doc/BRIEF.md
# Multi-Source DMA Channel Arbiter

This block decides which of sixteen DMA channels is handed to the transfer engine next. A channel becomes a candidate in one of three ways. Software can pulse a start bit. Another channel can chain into it when that channel finishes a transfer. Its peripheral can hold a hardware request line high. One grant is outstanding at any time. The engine reports the end of a transfer with a done pulse, and the arbiter then picks again.

Arbitration runs in one of two modes, and the mode can be changed between any two grants. In fixed mode the highest-numbered requester wins. In round-robin mode the search starts at the channel just after the one granted last and wraps around. A small per-channel link table says whether a finished transfer chains into another channel, and which channel that is. The table is written through a simple configuration port.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, grant_valid_o and busy_o are 0. The round-robin pointer is set so that the first round-robin search starts at channel 0.
- R2: A channel requests service when its pending start flag is set or its hw_req_i bit is 1. A pulse on sw_start_i[c] sets the pending flag of channel c. The flag stays set until channel c is granted, and the grant clears it. A start that arrives in the same cycle as that grant leaves the flag set.
- R3: When mode_i is 0 (fixed mode), the highest-numbered requesting channel is granted.
- R4: When mode_i is 1 (round-robin mode), the search starts at the channel after the last granted one and goes upward, wrapping from 15 to 0. The last granted channel is the final candidate of the search.
- R5: In a cycle where the arbiter is idle and at least one channel requests, the next clock edge starts a grant. grant_valid_o is 1 for exactly one cycle, grant_ch_o holds the channel number, and busy_o stays 1 until the transfer ends.
- R6: No new grant is issued while busy_o is 1. A hardware request from the channel being served is not granted again until after done_i.
- R7: done_i sampled while busy ends the transfer at that edge, so busy_o is 0 in the next cycle and the earliest new grant comes one edge later. done_i has no effect while the arbiter is idle.
- R8: A write with cfg_wr_i stores cfg_link_en_i and cfg_link_tgt_i for channel cfg_ch_i. When a transfer of channel c ends and c's link is enabled, the pending start flag of c's target is set. When the link is disabled, nothing is set.
- R9: mode_i is read in each grant cycle, so a change takes effect at the next grant. Grants made in either mode update the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 fixed priority, 1 round robin |
| sw_start_i | input | 16 | Per-channel software start pulses |
| hw_req_i | input | 16 | Per-channel peripheral request levels |
| cfg_wr_i | input | 1 | Link table write strobe |
| cfg_ch_i | input | 4 | Channel whose link entry is written |
| cfg_link_en_i | input | 1 | Link enable value to store |
| cfg_link_tgt_i | input | 4 | Link target channel to store |
| done_i | input | 1 | Engine reports end of the granted transfer |
| grant_valid_o | output | 1 | One-cycle strobe for a new grant |
| grant_ch_o | output | 4 | Granted channel number |
| busy_o | output | 1 | A grant is outstanding |

## Verification
The bench goes after the round-robin wrap and the case where the last granted channel is the only requester. A pointer that is off by one or never wraps would pick the wrong channel or skip that requester. It holds a second, higher request while the engine is busy. A design that arbitrates during a transfer would issue a second grant, or would serve the granted peripheral again before done. It checks that a software start is used up by its grant, and that a start arriving during the transfer is kept. A wrong clear would either repeat grants forever or lose the second request. Link chaining is checked with the link enabled and then disabled. A stray done pulse while idle must not disturb the next grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int unsigned DEF_NUM_CH = 16;

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;

    // Wrapping increment of a channel index
    function automatic int unsigned wrap_add(int unsigned base, int unsigned off, int unsigned n);
        int unsigned s;
        s = base + off;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/dma_req_collect.sv
module dma_req_collect #(
    parameter int unsigned NUM_CH = dma_arb_pkg::DEF_NUM_CH,
    localparam int unsigned CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] sw_start_i,
    input  logic [NUM_CH-1:0] hw_req_i,
    input  logic              clr_vld_i,
    input  logic [CH_W-1:0]   clr_ch_i,
    input  logic              link_vld_i,
    input  logic [CH_W-1:0]   link_ch_i,
    output logic [NUM_CH-1:0] req_o
);
    logic [NUM_CH-1:0] pend_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
        logic set_c;
        logic clr_c;
        assign set_c = sw_start_i[c] || (link_vld_i && (link_ch_i == CH_W'(c)));
        assign clr_c = clr_vld_i && (clr_ch_i == CH_W'(c));
        always_ff @(posedge clk) begin
            if (rst)        pend_q[c] <= 1'b0;
            else if (set_c) pend_q[c] <= 1'b1;
            else if (clr_c) pend_q[c] <= 1'b0;
        end
    end

    assign req_o = pend_q | hw_req_i;
endmodule

// File: rtl/dma_link_table.sv
module dma_link_table #(
    parameter int unsigned NUM_CH = dma_arb_pkg::DEF_NUM_CH,
    localparam int unsigned CH_W = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_i,
    input  logic [CH_W-1:0] wr_ch_i,
    input  logic            wr_en_i,
    input  logic [CH_W-1:0] wr_tgt_i,
    input  logic [CH_W-1:0] rd_ch_i,
    output logic            rd_en_o,
    output logic [CH_W-1:0] rd_tgt_o
);
    typedef struct packed {
        logic            en;
        logic [CH_W-1:0] tgt;
    } link_ent_t;

    link_ent_t ent_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[c] <= '0;
            end else if (wr_i && (wr_ch_i == CH_W'(c))) begin
                ent_q[c].en  <= wr_en_i;
                ent_q[c].tgt <= wr_tgt_i;
            end
        end
    end

    assign rd_en_o  = ent_q[rd_ch_i].en;
    assign rd_tgt_o = ent_q[rd_ch_i].tgt;
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    localparam int unsigned CH_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    input  arb_mode_e         mode_i,
    input  logic [CH_W-1:0]   last_i,
    output logic              any_o,
    output logic [CH_W-1:0]   win_o
);
    logic [CH_W-1:0] fix_win;
    logic [CH_W-1:0] rr_win;

    // Fixed order: a higher index overwrites a lower one
    always_comb begin
        fix_win = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req_i[i]) fix_win = CH_W'(i);
        end
    end

    // Rotating order: a smaller distance from the pointer overwrites a larger one
    always_comb begin
        rr_win = '0;
        for (int off = NUM_CH; off >= 1; off--) begin
            int unsigned idx;
            idx = wrap_add(int'(last_i), off, NUM_CH);
            if (req_i[idx]) rr_win = CH_W'(idx);
        end
    end

    assign any_o = |req_i;
    assign win_o = (mode_i == ARB_ROUND) ? rr_win : fix_win;
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    localparam int unsigned CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic [NUM_CH-1:0] sw_start_i,
    input  logic [NUM_CH-1:0] hw_req_i,
    input  logic              cfg_wr_i,
    input  logic [CH_W-1:0]   cfg_ch_i,
    input  logic              cfg_link_en_i,
    input  logic [CH_W-1:0]   cfg_link_tgt_i,
    input  logic              done_i,
    output logic              grant_valid_o,
    output logic [CH_W-1:0]   grant_ch_o,
    output logic              busy_o
);
    arb_state_e        state_q;
    logic [CH_W-1:0]   cur_q;
    logic [CH_W-1:0]   last_q;
    logic              gv_q;
    logic [NUM_CH-1:0] req_vec;
    logic              any_req;
    logic [CH_W-1:0]   win;
    logic              lk_en;
    logic [CH_W-1:0]   lk_tgt;
    logic              take;
    logic              finish;

    assign take   = (state_q == ST_IDLE) && any_req;
    assign finish = (state_q == ST_BUSY) && done_i;

    dma_req_collect #(.NUM_CH(NUM_CH)) u_collect (
        .clk        (clk),
        .rst        (rst),
        .sw_start_i (sw_start_i),
        .hw_req_i   (hw_req_i),
        .clr_vld_i  (take),
        .clr_ch_i   (win),
        .link_vld_i (finish && lk_en),
        .link_ch_i  (lk_tgt),
        .req_o      (req_vec)
    );

    dma_link_table #(.NUM_CH(NUM_CH)) u_links (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (cfg_wr_i),
        .wr_ch_i  (cfg_ch_i),
        .wr_en_i  (cfg_link_en_i),
        .wr_tgt_i (cfg_link_tgt_i),
        .rd_ch_i  (cur_q),
        .rd_en_o  (lk_en),
        .rd_tgt_o (lk_tgt)
    );

    dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req_i  (req_vec),
        .mode_i (arb_mode_e'(mode_i)),
        .last_i (last_q),
        .any_o  (any_req),
        .win_o  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            last_q  <= CH_W'(NUM_CH - 1);
            gv_q    <= 1'b0;
        end else begin
            gv_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (any_req) begin
                    state_q <= ST_BUSY;
                    cur_q   <= win;
                    last_q  <= win;
                    gv_q    <= 1'b1;
                end
                ST_BUSY: if (done_i) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign grant_valid_o = gv_q;
    assign grant_ch_o    = cur_q;
    assign busy_o        = (state_q == ST_BUSY);
endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
    parameter int unsigned NUM_CH = dma_arb_pkg::DEF_NUM_CH,
    localparam int unsigned CH_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_i,
    input logic              done_i,
    input logic              grant_valid_o,
    input logic [CH_W-1:0]   grant_ch_o,
    input logic              busy_o,
    input logic [NUM_CH-1:0] req_vec
);
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |=> !grant_valid_o);

    p_grant_busy_r5: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |-> busy_o);

    p_idle_grants_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (|req_vec)) |=> grant_valid_o);

    p_hold_ch_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !grant_valid_o) |-> $stable(grant_ch_o));

    p_no_grant_busy_r6: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |-> !$past(busy_o));

    p_done_ends_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && done_i) |=> !busy_o);

    p_idle_done_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && done_i && !(|req_vec)) |=> !busy_o);

    p_fixed_top_r3: assert property (@(posedge clk) disable iff (rst)
        (grant_valid_o && !$past(mode_i)) |-> ((($past(req_vec) >> grant_ch_o) >> 1) == '0));
endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode_i),
    .done_i        (done_i),
    .grant_valid_o (grant_valid_o),
    .grant_ch_o    (grant_ch_o),
    .busy_o        (busy_o),
    .req_vec       (req_vec)
);

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;
    // {mode, hw request mask, expected channel}
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 16'h0001, 4'd0},
        {1'b0, 16'h8001, 4'd15},
        {1'b0, 16'h0A50, 4'd11},
        {1'b1, 16'h0A50, 4'd4},
        {1'b1, 16'h0A50, 4'd6},
        {1'b1, 16'h0A50, 4'd9},
        {1'b1, 16'h0A50, 4'd11},
        {1'b1, 16'h0A50, 4'd4},
        {1'b1, 16'h0010, 4'd4},
        {1'b1, 16'h8000, 4'd15},
        {1'b1, 16'h8001, 4'd0},
        {1'b0, 16'h0003, 4'd1},
        {1'b1, 16'h0003, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_i = 1'b0;
    logic [15:0] sw_start_i = '0;
    logic [15:0] hw_req_i = '0;
    logic        cfg_wr_i = 1'b0;
    logic [3:0]  cfg_ch_i = '0;
    logic        cfg_link_en_i = 1'b0;
    logic [3:0]  cfg_link_tgt_i = '0;
    logic        done_i = 1'b0;
    logic        grant_valid_o;
    logic [3:0]  grant_ch_o;
    logic        busy_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_arbiter dut_i (
        .clk(clk), .rst(rst), .mode_i(mode_i), .sw_start_i(sw_start_i),
        .hw_req_i(hw_req_i), .cfg_wr_i(cfg_wr_i), .cfg_ch_i(cfg_ch_i),
        .cfg_link_en_i(cfg_link_en_i), .cfg_link_tgt_i(cfg_link_tgt_i),
        .done_i(done_i), .grant_valid_o(grant_valid_o),
        .grant_ch_o(grant_ch_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Waits for a grant strobe; returns channel or -1 on timeout
    task automatic wait_grant(output int ch);
        ch = -1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (grant_valid_o) begin
                ch = int'(grant_ch_o);
                break;
            end
        end
    endtask

    task automatic finish_xfer();
        step();
        done_i = 1'b1;
        step();
        done_i = 1'b0;
    endtask

    task automatic pulse_sw(input int c);
        sw_start_i[c] = 1'b1;
        step();
        sw_start_i = '0;
    endtask

    task automatic write_link(input int c, input bit en, input int tgt);
        cfg_wr_i = 1'b1; cfg_ch_i = 4'(c); cfg_link_en_i = en; cfg_link_tgt_i = 4'(tgt);
        step();
        cfg_wr_i = 1'b0;
    endtask

    task automatic expect_quiet(input string tag, input int cycles);
        int seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (grant_valid_o) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int ch;
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        chk(grant_valid_o == 1'b0, "R1 reset grant_valid", grant_valid_o, 0);
        chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
        step();
        // R1: first round-robin search begins at channel 0
        mode_i = 1'b1; hw_req_i = 16'h8001;
        wait_grant(ch);
        chk(ch == 0, "R1 rr start", ch, 0);
        hw_req_i = '0;
        finish_xfer();

        // R3 R4 R9: vector table
        for (int v = 0; v < NV; v++) begin
            mode_i = VEC[v][20];
            hw_req_i = VEC[v][19:4];
            wait_grant(ch);
            chk(ch == int'(VEC[v][3:0]), $sformatf("R3/R4 vector %0d", v), ch, int'(VEC[v][3:0]));
            hw_req_i = '0;
            finish_xfer();
        end

        // R5 R6: strobe length, no grant while busy
        mode_i = 1'b0; hw_req_i = 16'h0008;
        wait_grant(ch);
        chk(ch == 3, "R5 grant ch", ch, 3);
        @(negedge clk);
        chk(grant_valid_o == 1'b0, "R5 strobe one cycle", grant_valid_o, 0);
        chk(busy_o == 1'b1, "R5 busy held", busy_o, 1);
        hw_req_i = 16'h0408;
        expect_quiet("R6 no grant while busy", 6);
        chk(busy_o == 1'b1, "R6 still busy", busy_o, 1);
        finish_xfer();
        wait_grant(ch);
        chk(ch == 10, "R6 next after done", ch, 10);
        hw_req_i = '0;
        finish_xfer();

        // R7: done ends transfer, done while idle ignored
        @(negedge clk);
        chk(busy_o == 1'b0, "R7 idle after done", busy_o, 0);
        step();
        done_i = 1'b1; step(); done_i = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R7 idle done ignored", busy_o, 0);
        step();
        pulse_sw(1);
        wait_grant(ch);
        chk(ch == 1, "R7 grant after stray done", ch, 1);
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b1, "R7 stray done not latched", busy_o, 1);
        finish_xfer();

        // R2: software start consumed by grant
        expect_quiet("R2 start cleared", 6);
        chk(busy_o == 1'b0, "R2 idle after one grant", busy_o, 0);
        step();
        // R2: start during own transfer stays pending
        pulse_sw(5);
        wait_grant(ch);
        chk(ch == 5, "R2 sw grant", ch, 5);
        step();
        pulse_sw(5);
        finish_xfer();
        wait_grant(ch);
        chk(ch == 5, "R2 pending kept", ch, 5);
        finish_xfer();
        expect_quiet("R2 no repeat", 5);

        // R8: link chaining
        step();
        write_link(2, 1'b1, 7);
        pulse_sw(2);
        wait_grant(ch);
        chk(ch == 2, "R8 source grant", ch, 2);
        finish_xfer();
        wait_grant(ch);
        chk(ch == 7, "R8 linked grant", ch, 7);
        finish_xfer();
        expect_quiet("R8 chain stops", 6);
        step();
        write_link(2, 1'b0, 7);
        pulse_sw(2);
        wait_grant(ch);
        chk(ch == 2, "R8 source grant again", ch, 2);
        finish_xfer();
        expect_quiet("R8 link disabled", 6);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule